// File: doc/BRIEF.md
# GPIO Pin Interrupt Detection Unit

This block watches the eight input pins of a GPIO port and turns configured pin conditions into interrupt requests. Software picks, pin by pin, one of five trigger kinds: high level, low level, rising edge, falling edge, or any edge. A detected condition sets a sticky raw flag. The raw flags are ANDed with a mask to form the masked flags, and the OR of the masked flags drives a single interrupt line to the interrupt controller.

Pins enter through a two-stage synchronizer. An edge is the synchronized value compared with its value one cycle earlier. Three configuration bits per pin select the trigger kind. The sense bit chooses level or edge. The polarity bit chooses high/rising or low/falling. The any-edge bit makes the pin trigger on both edges, and it has this effect only when the sense bit selects edge mode. An interrupt service routine reads the raw or masked flags and acknowledges them by writing ones to the acknowledge register. While a level condition is still present, it sets its flag again on every cycle. When a condition and an acknowledge reach the same bit in the same cycle, the condition wins.

The register bus is a single-cycle write strobe with a combinational read. There is no state machine, because each pin is a registered flag with set and clear terms.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the sense, any-edge, polarity, mask and raw-flag registers all read 0, and irq_o is 0.
- R2: With sense=1 (level mode), a pin sets its raw flag while its synchronized level is high (polarity=1) or low (polarity=0).
- R3: With sense=0, any-edge=0, a pin sets its raw flag only on a rising edge (polarity=1) or only on a falling edge (polarity=0).
- R4: With sense=0 and any-edge=1, both edges set the raw flag whatever the polarity. With sense=1, the any-edge bit has no effect.
- R5: Raw flags are set whatever the mask holds.
- R6: The masked-flag register (0x418) reads raw AND mask, and irq_o is 1 exactly when that value is nonzero.
- R7: Writing to the acknowledge register (0x41C) clears the raw flags at the bit positions written as 1 and leaves the bits written as 0 unchanged. The acknowledge register reads 0. Writes to the raw (0x414) and masked (0x418) addresses change nothing.
- R8: In level mode, an acknowledge does not keep the flag clear while the level is still present. Once the level has gone away, an acknowledge clears the flag.
- R9: When a condition and an acknowledge hit the same bit in the same cycle, the raw flag ends up set.
- R10: A pin change applied before rising edge k shows in the raw flag after edge k+2 and not earlier. A raw flag never becomes set without a detected condition.
- R11: Register offsets: sense 0x404, any-edge 0x408, polarity 0x40C, mask 0x410, raw 0x414, masked 0x418, acknowledge 0x41C. Bit i of each register belongs to pin i. The configuration registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin inputs |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The checker checks on every cycle that:
- a condition beats a same-cycle acknowledge;
- an acknowledged bit with no condition drops;
- no raw flag rises without a detected condition;
- the interrupt stays low while the mask is zero.

Only the bench scenarios can show the following:
- the per-pin trigger decode across all eight sense/any-edge/polarity combinations, with both transition directions;
- the three-edge latency;
- a level condition surviving an acknowledge;
- register readback and writes to read-only addresses being ignored.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_SENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_ANYE  = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_POL   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_MSK   = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_ACK   = 12'h41C;

    typedef enum logic [2:0] {
        TRIG_FALL,
        TRIG_RISE,
        TRIG_ANY,
        TRIG_LOW,
        TRIG_HIGH
    } trig_e;

    function automatic trig_e trig_decode(input logic sense, input logic anye,
                                          input logic pol);
        trig_e t;
        if (sense)     t = pol ? TRIG_HIGH : TRIG_LOW;
        else if (anye) t = TRIG_ANY;
        else           t = pol ? TRIG_RISE : TRIG_FALL;
        return t;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign cur_o  = chain_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic sense,
    input  logic anye,
    input  logic pol,
    input  logic cur,
    input  logic prev,
    output logic hit
);
    trig_e mode;
    logic  rise;
    logic  fall;

    assign mode = trig_decode(sense, anye, pol);
    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            TRIG_FALL: hit = fall;
            TRIG_RISE: hit = rise;
            TRIG_ANY:  hit = rise | fall;
            TRIG_LOW:  hit = ~cur;
            TRIG_HIGH: hit = cur;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      hit_i,
    output logic [W-1:0]      sense_o,
    output logic [W-1:0]      anye_o,
    output logic [W-1:0]      pol_o,
    output logic [W-1:0]      mask_o,
    output logic [W-1:0]      raw_o,
    output logic [W-1:0]      ack_o,
    output logic [W-1:0]      rdata_o
);
    logic [W-1:0] sense_q, anye_q, pol_q, mask_q, raw_q;
    logic [W-1:0] msk_w;

    assign ack_o = (bus_wr && bus_addr == OFF_ACK) ? bus_wdata : '0;
    assign msk_w = raw_q & mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            anye_q  <= '0;
            pol_q   <= '0;
            mask_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_SENSE) sense_q <= bus_wdata;
            if (bus_addr == OFF_ANYE)  anye_q  <= bus_wdata;
            if (bus_addr == OFF_POL)   pol_q   <= bus_wdata;
            if (bus_addr == OFF_MASK)  mask_q  <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~ack_o) | hit_i;
    end

    always_comb begin
        rdata_o = '0;
        unique case (bus_addr)
            OFF_SENSE: rdata_o = sense_q;
            OFF_ANYE:  rdata_o = anye_q;
            OFF_POL:   rdata_o = pol_q;
            OFF_MASK:  rdata_o = mask_q;
            OFF_RAW:   rdata_o = raw_q;
            OFF_MSK:   rdata_o = msk_w;
            default:   rdata_o = '0;
        endcase
    end

    assign sense_o = sense_q;
    assign anye_o  = anye_q;
    assign pol_o   = pol_q;
    assign mask_o  = mask_q;
    assign raw_o   = raw_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pin_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq_o
);
    logic [W-1:0] cur_w, prev_w, hit_w;
    logic [W-1:0] sense_w, anye_w, pol_w, mask_w, raw_w, ack_w;

    gpio_irq_sync #(.W(W), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            gpio_irq_detect u_det (
                .sense (sense_w[i]),
                .anye  (anye_w[i]),
                .pol   (pol_w[i]),
                .cur   (cur_w[i]),
                .prev  (prev_w[i]),
                .hit   (hit_w[i])
            );
        end
    endgenerate

    gpio_irq_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit_i     (hit_w),
        .sense_o   (sense_w),
        .anye_o    (anye_w),
        .pol_o     (pol_w),
        .mask_o    (mask_w),
        .raw_o     (raw_w),
        .ack_o     (ack_w),
        .rdata_o   (bus_rdata)
    );

    assign irq_o = |(raw_w & mask_w);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] hit,
    input logic [W-1:0] ack,
    input logic [W-1:0] raw,
    input logic [W-1:0] mask,
    input logic         irq
);
    // R9: a condition beats a same-cycle acknowledge
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(hit)) == $past(hit)));

    // R7: acknowledged bit with no condition is cleared
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(ack & ~hit)) == '0));

    // R10: a flag only rises on a detected condition
    a_r10_set_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & ~$past(raw) & ~$past(hit)) == '0));

    // R6: interrupt stays low with nothing unmasked
    a_r6_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

bind gpio_irq_unit gpio_irq_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit_w),
    .ack   (ack_w),
    .raw   (raw_w),
    .mask  (mask_w),
    .irq   (irq_o)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_SENSE = 12'h404, A_ANYE = 12'h408, A_POL = 12'h40C,
                            A_MASK = 12'h410, A_RAW = 12'h414, A_MSK = 12'h418,
                            A_ACK = 12'h41C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0;
    logic       bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_unit u_gpio_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, pre, post, snap;
        logic [7:0] sense, anye, pol;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        rd(A_SENSE, d); check("R1 sense", d, 8'h00);
        rd(A_ANYE, d);  check("R1 anye", d, 8'h00);
        rd(A_POL, d);   check("R1 pol", d, 8'h00);
        rd(A_MASK, d);  check("R1 mask", d, 8'h00);
        rd(A_RAW, d);   check("R1 raw", d, 8'h00);
        check("R1 irq", {7'd0, irq_o}, 8'h00);

        // Sweep: pin i uses configuration i = {sense,anye,pol}
        sense = 8'hF0; anye = 8'hCC; pol = 8'hAA;
        wr(A_SENSE, sense); wr(A_ANYE, anye); wr(A_POL, pol);
        // R11 readback
        rd(A_SENSE, d); check("R11 sense readback", d, sense);
        rd(A_ANYE, d);  check("R11 anye readback", d, anye);
        rd(A_POL, d);   check("R11 pol readback", d, pol);
        for (int st = 0; st < 2; st++) begin
            for (int pat = 0; pat < 4; pat++) begin
                logic [7:0] a0, a1;
                a0 = (st == 0) ? 8'h00 : 8'hFF;
                a1 = (pat == 0) ? ~a0 : (pat == 1) ? (a0 ^ 8'h0F)
                   : (pat == 2) ? (a0 ^ 8'hF0) : (a0 ^ 8'h55);
                @(negedge clk); pin_i = a0;
                cycles(4);
                wr(A_ACK, 8'hFF);
                cycles(1);
                for (int i = 0; i < 8; i++)
                    pre[i] = sense[i] & (pol[i] ? a0[i] : ~a0[i]);
                rd(A_RAW, d); check("R2 R8 level before change", d, pre);
                for (int i = 0; i < 8; i++) begin
                    logic rise, fall;
                    rise = a1[i] & ~a0[i];
                    fall = ~a1[i] & a0[i];
                    if (sense[i]) post[i] = pre[i] | (pol[i] ? a1[i] : ~a1[i]);
                    else post[i] = anye[i] ? (rise | fall) : (pol[i] ? rise : fall);
                end
                pin_i = a1;
                @(negedge clk);
                rd(A_RAW, d); check("R10 no change after one edge", d, pre);
                @(negedge clk);
                rd(A_RAW, d); check("R10 no change after two edges", d, pre);
                @(negedge clk);
                rd(A_RAW, d); check("R2 R3 R4 decode after three edges", d, post);
                // R5 mask is zero, yet flags set; irq low
                check("R5 irq low with mask zero", {7'd0, irq_o}, 8'h00);
                wr(A_MASK, 8'h5A);
                rd(A_RAW, snap);
                rd(A_MSK, d); check("R6 masked flags", d, snap & 8'h5A);
                check("R6 irq", {7'd0, irq_o}, {7'd0, |(snap & 8'h5A)});
                wr(A_MASK, 8'h00);
            end
        end

        // R7 acknowledge semantics, edge-rising mode on all pins
        wr(A_SENSE, 8'h00); wr(A_ANYE, 8'h00); wr(A_POL, 8'hFF);
        @(negedge clk); pin_i = 8'h00;
        cycles(4);
        wr(A_ACK, 8'hFF);
        @(negedge clk); pin_i = 8'hFF;
        cycles(4);
        rd(A_RAW, d); check("R3 all rising", d, 8'hFF);
        wr(A_ACK, 8'h0F);
        rd(A_RAW, d); check("R7 partial ack", d, 8'hF0);
        wr(A_ACK, 8'h00);
        rd(A_RAW, d); check("R7 zero ack no effect", d, 8'hF0);
        wr(A_RAW, 8'h00);
        rd(A_RAW, d); check("R7 raw write ignored", d, 8'hF0);
        wr(A_MSK, 8'hFF);
        rd(A_MASK, d); check("R7 masked write ignored", d, 8'h00);
        rd(A_ACK, d); check("R7 ack reads zero", d, 8'h00);

        // R8 level high persists over acknowledge
        wr(A_SENSE, 8'hFF);
        wr(A_ACK, 8'hFF);
        cycles(1);
        rd(A_RAW, d); check("R8 level survives ack", d, 8'hFF);
        @(negedge clk); pin_i = 8'h00;
        cycles(4);
        wr(A_ACK, 8'hFF);
        cycles(1);
        rd(A_RAW, d); check("R8 ack after level gone", d, 8'h00);

        // R9 race: rising edge on pin 0 meets acknowledge
        wr(A_SENSE, 8'h00);
        wr(A_ACK, 8'hFF);
        @(negedge clk); pin_i = 8'h01;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 8'h01;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(A_RAW, d); check("R9 set wins", d, 8'h01);
        wr(A_MASK, 8'h01);
        check("R6 irq single pin", {7'd0, irq_o}, 8'h01);
        wr(A_ACK, 8'h01);
        check("R6 irq drops after ack", {7'd0, irq_o}, 8'h00);
        rd(A_MASK, d); check("R11 mask readback", d, 8'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule